// File: doc/BRIEF.md
# Serial Transmitter with Character Queue

This block turns queued characters into asynchronous serial frames. Software or a neighbouring block pushes words into a 16-entry queue. The queue keeps the low 9 bits of each word. A small state machine takes one character at a time from the queue and sends a frame on the serial line. The frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit or wake-up bit, then a high stop interval. All timing comes from an external enable pulse that runs at 16 times the bit rate.

The frame shape is chosen by a 3-bit format code, a 2-bit stop-length code and a parity-sense bit. The stop interval can be half a bit, one bit, one and a half bits or two bits long. When clear-to-send gating is enabled, no new frame starts while the clear-to-send input is low. A frame that is already in flight always completes. A loopback enable moves the frames onto a separate loop output and holds the external line at idle. A flush input empties the queue.

The state machine has four states:
- IDLE: the line is high and no frame is in progress.
- START: the start bit is being sent.
- DATA: the data, parity or wake-up bits are being sent.
- STOP: the stop interval is being sent.

The transitions are named as follows:
- launch (IDLE to START): on a tick, when the queue holds a character and the clear-to-send gate is open.
- start-done (START to DATA): after 16 ticks.
- data-done (DATA to STOP): after the 16th tick of the last bit.
- stop-done (STOP to IDLE): at the end of the stop interval, when nothing can be launched.
- chain (STOP to START): at the end of the stop interval, when another character can be launched at once.

Top module: `ser_tx`

## Requirements
- R1: The queue holds 16 entries of 9 bits, each taken from bits 8:0 of the written word. Characters leave the queue in the order they were written.
- R2: A frame is a low start bit lasting 16 ticks, followed by payload bits sent least significant bit first, each lasting 16 ticks. A frame is launched only on a tick.
- R3: The format code selects the payload:
  - 001: 8 data bits.
  - 011: 7 data bits (entry bits 6:0) followed by a parity bit.
  - 100: 9 data bits.
  - 101: 8 data bits followed by entry bit 8 as a wake-up bit.
  - 111: 8 data bits followed by a parity bit.
  - Any other code: sent as 001.
- R4: The parity bit is the XOR of the data bits when the parity-sense bit is 0 (even parity). It is the inverse of that XOR when the parity-sense bit is 1 (odd parity).
- R5: The stop interval holds the line high for 8, 16, 24 or 32 ticks for stop codes 00, 01, 10 and 11. A queued character starts immediately after the stop interval, with no extra idle time.
- R6: The status outputs are:
  - tx_empty is 1 when the queue is empty and no frame is in progress.
  - half_empty is 1 when the queue holds 8 or fewer entries.
  - fifo_full is 1 when the queue holds 16 entries.

  Each flag follows the clock edge that changes the queue.
- R7: A write while the queue is full is dropped, and the queue contents stay unchanged.
- R8: While cts_en is 1 and cts_ok is 0, no new frame starts. A frame already in progress completes.
- R9: A one-cycle pulse on fifo_flush empties the queue, and the flushed characters are never sent. Flush takes priority over a write in the same cycle.
- R10: While lpbk_en is 1, frames appear on loop_line and tx_line stays high. While lpbk_en is 0, frames appear on tx_line and loop_line stays high.
- R11: After reset, both lines are high, tx_empty and half_empty are 1, and fifo_full is 0. Both lines are high whenever tx_empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| wr_en | input | 1 | Write one word into the queue |
| wr_data | input | WORD_W | Written word; only bits 8:0 are kept |
| fifo_flush | input | 1 | Empty the queue |
| fmt_code | input | 3 | Frame format code |
| stop_code | input | 2 | Stop interval length code |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cts_en | input | 1 | Enable clear-to-send gating |
| cts_ok | input | 1 | Clear-to-send, active high |
| lpbk_en | input | 1 | Route frames to loop_line |
| tx_line | output | 1 | External serial line |
| loop_line | output | 1 | Loopback serial line |
| tx_empty | output | 1 | Queue empty and no frame in progress |
| half_empty | output | 1 | Queue holds 8 or fewer entries |
| fifo_full | output | 1 | Queue holds 16 entries |

## Verification
The status flags are due one clock after the edge that takes a write or a flush. The bench therefore drives inputs on a falling edge and checks the flags on the next falling edge.

Line transitions happen on the clock edge that consumes a tick. With one tick every two clocks, each bit lasts exactly 32 clocks. After each falling start edge, the bench receiver counts clocks and samples every bit at its midpoint.

The stop interval is measured as an exact count of high cycles. This measurement is made only when the next character was already queued and the clear-to-send gate was open. In that case the chain transition is due with no extra idle time.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    localparam int CHAR_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_t;

    typedef struct packed {
        logic [3:0]        nbits;
        logic [CHAR_W-1:0] bits;
    } frame_t;

    // Payload shaping per format code; unknown codes fall back to 8 plain bits.
    function automatic frame_t build_frame(input logic [2:0] fmt,
                                           input logic odd,
                                           input logic [CHAR_W-1:0] d);
        frame_t f;
        f.nbits = 4'd8;
        f.bits  = {1'b0, d[7:0]};
        case (fmt)
            3'b011: f.bits = {1'b0, (^d[6:0]) ^ odd, d[6:0]};
            3'b100, 3'b101: begin
                f.nbits = 4'd9;
                f.bits  = d;
            end
            3'b111: begin
                f.nbits = 4'd9;
                f.bits  = {(^d[7:0]) ^ odd, d[7:0]};
            end
            default: f.bits = {1'b0, d[7:0]};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/ser_tx_fifo.sv
module ser_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 9,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             push_ok, pop_ok;

    assign push_ok = push && !flush && (count != CNT_W'(DEPTH));
    assign pop_ok  = pop && !flush && (count != '0);
    assign rdata   = mem[rptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/ser_tx_fsm.sv
module ser_tx_fsm
    import ser_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    localparam int HALF = TICKS_PER_BIT / 2,
    localparam int TW   = $clog2(2 * TICKS_PER_BIT) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              avail,
    input  logic              gate_open,
    input  logic [CHAR_W-1:0] data,
    input  logic [2:0]        fmt,
    input  logic [1:0]        stop_sel,
    input  logic              par_odd,
    output logic              pop,
    output logic              busy,
    output logic              serial
);

    tx_state_t         state, state_d;
    logic [TW-1:0]     tcnt, stop_len;
    logic [3:0]        bidx, nbits;
    logic [CHAR_W-1:0] shreg;
    logic              go, bit_end, stop_end, load;
    frame_t            nf;

    assign nf       = build_frame(fmt, par_odd, data);
    assign go       = tick && avail && gate_open;
    assign bit_end  = tick && (tcnt == TW'(TICKS_PER_BIT - 1));
    assign stop_end = tick && (tcnt == stop_len - TW'(1));

    // Next-state logic: launch, start-done, data-done, stop-done / chain.
    always_comb begin
        state_d = state;
        load    = 1'b0;
        unique case (state)
            ST_IDLE: if (go) begin
                state_d = ST_START;
                load    = 1'b1;
            end
            ST_START: if (bit_end) state_d = ST_DATA;
            ST_DATA:  if (bit_end && (bidx == nbits - 4'd1)) state_d = ST_STOP;
            ST_STOP: if (stop_end) begin
                state_d = go ? ST_START : ST_IDLE;
                load    = go;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and frame datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            nbits    <= 4'd8;
            shreg    <= '0;
            stop_len <= TW'(TICKS_PER_BIT);
        end else begin
            state <= state_d;
            if (load) begin
                shreg    <= nf.bits;
                nbits    <= nf.nbits;
                stop_len <= TW'((32'(stop_sel) + 1) * HALF);
                tcnt     <= '0;
                bidx     <= '0;
            end else if (state != state_d) begin
                tcnt <= '0;
            end else if (tick) begin
                if (state == ST_DATA && bit_end) begin
                    tcnt  <= '0;
                    bidx  <= bidx + 4'd1;
                    shreg <= shreg >> 1;
                end else begin
                    tcnt <= tcnt + TW'(1);
                end
            end
        end
    end

    // Outputs.
    always_comb begin
        pop  = load;
        busy = (state != ST_IDLE);
        unique case (state)
            ST_START: serial = 1'b0;
            ST_DATA:  serial = shreg[0];
            default:  serial = 1'b1;
        endcase
    end

endmodule

// File: rtl/ser_tx.sv
module ser_tx
    import ser_tx_pkg::*;
#(
    parameter int WORD_W        = 16,
    parameter int DEPTH         = 16,
    parameter int TICKS_PER_BIT = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              fifo_flush,
    input  logic [2:0]        fmt_code,
    input  logic [1:0]        stop_code,
    input  logic              par_odd,
    input  logic              cts_en,
    input  logic              cts_ok,
    input  logic              lpbk_en,
    output logic              tx_line,
    output logic              loop_line,
    output logic              tx_empty,
    output logic              half_empty,
    output logic              fifo_full
);

    logic [CNT_W-1:0]  fifo_cnt;
    logic [CHAR_W-1:0] head;
    logic              pop, busy, serial;

    ser_tx_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fifo_flush),
        .push  (wr_en),
        .wdata (wr_data[CHAR_W-1:0]),
        .pop   (pop),
        .rdata (head),
        .count (fifo_cnt)
    );

    ser_tx_fsm #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .avail     (fifo_cnt != '0),
        .gate_open (!cts_en || cts_ok),
        .data      (head),
        .fmt       (fmt_code),
        .stop_sel  (stop_code),
        .par_odd   (par_odd),
        .pop       (pop),
        .busy      (busy),
        .serial    (serial)
    );

    assign tx_empty   = (fifo_cnt == '0) && !busy;
    assign half_empty = (fifo_cnt <= CNT_W'(DEPTH / 2));
    assign fifo_full  = (fifo_cnt == CNT_W'(DEPTH));
    assign tx_line    = lpbk_en ? 1'b1 : serial;
    assign loop_line  = lpbk_en ? serial : 1'b1;

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             fifo_flush,
    input logic             pop,
    input logic             busy,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             cts_en,
    input logic             cts_ok,
    input logic             lpbk_en,
    input logic             tx_line,
    input logic             loop_line,
    input logic             tx_empty,
    input logic             half_empty,
    input logic             fifo_full
);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == CNT_W'(DEPTH) && wr_en && !pop && !fifo_flush) |=> (fifo_cnt == CNT_W'(DEPTH)));

    assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (tx_line && loop_line));

    assert_loop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_en ? tx_line : loop_line);

    assert_cts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_en && !cts_ok && !busy) |=> !busy);

    assert_full_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> (!tx_empty && !half_empty));

endmodule

bind ser_tx ser_tx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .fifo_flush (fifo_flush),
    .pop        (pop),
    .busy       (busy),
    .fifo_cnt   (fifo_cnt),
    .cts_en     (cts_en),
    .cts_ok     (cts_ok),
    .lpbk_en    (lpbk_en),
    .tx_line    (tx_line),
    .loop_line  (loop_line),
    .tx_empty   (tx_empty),
    .half_empty (half_empty),
    .fifo_full  (fifo_full)
);

// File: tb/ser_tx_tb.sv
`timescale 1ns/1ps
module ser_tx_tb;

    localparam int TDIV   = 2;
    localparam int BITCYC = 16 * TDIV;
    localparam int LIM    = 40 * TDIV;

    typedef struct {
        int         n;
        logic [8:0] bits;
        int         stop;
    } exp_t;

    logic        clk = 0, rst_n = 0, tick16 = 0, wr_en = 0, fifo_flush = 0;
    logic [15:0] wr_data = '0;
    logic [2:0]  fmt_code = 3'b001;
    logic [1:0]  stop_code = 2'b01;
    logic        par_odd = 0, cts_en = 0, cts_ok = 1, lpbk_en = 0;
    logic        tx_line, loop_line, tx_empty, half_empty, fifo_full;

    int   n_chk = 0, n_bad = 0, cyc = 0;
    bit   done = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    ser_tx u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_flush(fifo_flush), .fmt_code(fmt_code), .stop_code(stop_code),
        .par_odd(par_odd), .cts_en(cts_en), .cts_ok(cts_ok), .lpbk_en(lpbk_en),
        .tx_line(tx_line), .loop_line(loop_line), .tx_empty(tx_empty),
        .half_empty(half_empty), .fifo_full(fifo_full)
    );

    wire mon_line   = lpbk_en ? loop_line : tx_line;
    wire quiet_line = lpbk_en ? tx_line : loop_line;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic exp_t mk_exp(input logic [2:0] m, input bit odd,
                                    input logic [8:0] d, input logic [1:0] st);
        exp_t e;
        bit p = 0;
        e.stop = (int'(st) + 1) * 8;
        case (m)
            3'b011: begin
                for (int k = 0; k < 7; k++) p ^= d[k];
                e.n = 8; e.bits = {1'b0, p ^ odd, d[6:0]};
            end
            3'b100, 3'b101: begin e.n = 9; e.bits = d; end
            3'b111: begin
                for (int k = 0; k < 8; k++) p ^= d[k];
                e.n = 9; e.bits = {p ^ odd, d[7:0]};
            end
            default: begin e.n = 8; e.bits = {1'b0, d[7:0]}; end
        endcase
        return e;
    endfunction

    task automatic do_write(input logic [15:0] w, input bit accepted);
        @(negedge clk);
        wr_en = 1; wr_data = w;
        if (accepted) exp_q.push_back(mk_exp(fmt_code, par_odd, w[8:0], stop_code));
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (LIM + 10) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all queued frames sent", exp_q.size(), 0);
    endtask

    // Tick generator: one cycle high every TDIV cycles.
    initial begin
        forever begin
            @(negedge clk);
            tick16 = (cyc % TDIV) == 0;
            cyc++;
        end
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Receiver monitor.
    initial begin : mon
        bit started = 0;
        forever begin
            exp_t       e;
            logic [8:0] rx;
            int         run;
            bit         chain;
            if (!started) begin
                @(negedge clk);
                while (mon_line !== 1'b0 || !rst_n) @(negedge clk);
            end
            started = 0;
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected frame (flushed or dropped char sent)", 1, 0);
                e.n = 9; e.bits = '0; e.stop = 8;
            end else begin
                e = exp_q.pop_front();
            end
            repeat (BITCYC / 2) @(negedge clk);
            chk(mon_line === 1'b0, "R2 start bit low", mon_line, 0);
            chk(quiet_line === 1'b1, "R10 unused line idle", quiet_line, 1);
            rx = '0;
            for (int k = 0; k < e.n; k++) begin
                repeat (BITCYC) @(negedge clk);
                rx[k] = mon_line;
            end
            chk(rx == e.bits, "R3 R4 payload bits", rx, e.bits);
            repeat (BITCYC / 2) @(negedge clk);
            chain = (exp_q.size() > 0) && (!cts_en || cts_ok);
            run = 0;
            while (mon_line === 1'b1 && run < LIM) begin
                run++;
                @(negedge clk);
            end
            started = (mon_line === 1'b0);
            if (chain) chk(run == e.stop * TDIV, "R5 stop length in cycles", run, e.stop * TDIV);
        end
    end

    initial begin : main
        logic [2:0] modes [6];
        void'($urandom(32'h5EED_1234));
        modes[0] = 3'b001; modes[1] = 3'b011; modes[2] = 3'b100;
        modes[3] = 3'b101; modes[4] = 3'b111; modes[5] = 3'b010;

        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(tx_line === 1'b1 && loop_line === 1'b1, "R11 lines high after reset", {tx_line, loop_line}, 3);
        chk(tx_empty === 1'b1, "R11 tx_empty after reset", tx_empty, 1);
        chk(half_empty === 1'b1 && fifo_full === 1'b0, "R11 half/full after reset", {half_empty, fifo_full}, 2);

        // Fill with clear-to-send blocked: status thresholds and dropped write.
        cts_en = 1; cts_ok = 0;
        for (int i = 0; i < 8; i++) do_write(16'hA500 + 16'(i * 37), 1);
        chk(half_empty === 1'b1, "R6 half_empty at 8 entries", half_empty, 1);
        do_write(16'h0155, 1);
        chk(half_empty === 1'b0, "R6 half_empty clear at 9 entries", half_empty, 0);
        for (int i = 9; i < 16; i++) do_write(16'hFE00 + 16'(i * 19), 1);
        chk(fifo_full === 1'b1 && tx_empty === 1'b0, "R6 full at 16 entries", {fifo_full, tx_empty}, 2);
        do_write(16'h01AA, 0);
        chk(fifo_full === 1'b1, "R7 still full after dropped write", fifo_full, 1);
        repeat (300) @(negedge clk);
        chk(tx_line === 1'b1 && tx_empty === 1'b0, "R8 no start while blocked", {tx_line, tx_empty}, 2);
        cts_ok = 1;
        wait_idle();

        // Flush.
        cts_ok = 0;
        for (int i = 0; i < 5; i++) do_write(16'(32'h33 + i), 1);
        chk(tx_empty === 1'b0, "R9 queue occupied before flush", tx_empty, 0);
        @(negedge clk); fifo_flush = 1;
        @(negedge clk); fifo_flush = 0;
        exp_q.delete();
        chk(tx_empty === 1'b1 && half_empty === 1'b1, "R9 empty after flush", {tx_empty, half_empty}, 3);
        cts_ok = 1;
        repeat (2000) @(negedge clk);
        chk(tx_line === 1'b1 && tx_empty === 1'b1, "R9 nothing sent after flush", {tx_line, tx_empty}, 3);

        // Clear-to-send dropped mid-frame.
        do_write(16'h00C3, 1);
        do_write(16'h003C, 1);
        while (tx_line !== 1'b0) @(negedge clk);
        cts_ok = 0;
        repeat (12 * BITCYC + 200) @(negedge clk);
        chk(exp_q.size() == 1, "R8 in-flight frame done, next held", exp_q.size(), 1);
        chk(tx_empty === 1'b0 && tx_line === 1'b1, "R8 held character waits", {tx_empty, tx_line}, 1);
        cts_ok = 1;
        wait_idle();
        cts_en = 0;

        // Random phases over every format, stop code and both routes.
        for (int p = 0; p < 12; p++) begin
            int nw;
            fmt_code  = modes[p % 6];
            stop_code = 2'(p % 4);
            par_odd   = 1'($urandom);
            lpbk_en   = (p % 3) == 1;
            nw = 1 + int'($urandom % 8);
            for (int i = 0; i < nw; i++) do_write(16'($urandom), 1);
            wait_idle();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule